// File: doc/BRIEF.md
# Two-Convention 16-Bit DMA Slave Port

This block sits between an external DMA controller and a byte-wide FIFO inside a storage controller. It places a 16-bit data bus, with one odd-parity bit per byte lane, on the DMA side. It accepts either of two bus conventions, chosen by a static select input. In the strobe-pair convention, separate read and write strobes mark a cycle, an address bit selects the low lane and a high-byte enable selects the high lane. In the direction-line convention, a read/write line sets the direction and two data strobes, one per lane, mark the cycle and its valid lanes. The two conventions put the first byte of a word on opposite lanes.

The port raises a request when the FIFO can take or supply the next transfer. It moves data only while the acknowledge input is high. It counts bytes against a total and against a block size. If the permit input is low when a block boundary is reached, the port waits there. Every bus pin, including the data pins, passes through a two-stage synchronizer. A transfer is committed when the strobe of the cycle is released. The internal core pushes bytes into the FIFO for bus reads and pops bytes from it for bus writes.

Top module: `dma_slave_port`

## Requirements
- R1: After reset, `dreq`, `par_err` and `dq_oe` are 0 and `fifo_level` is 0.
- R2: With `conv_sel`=0 (strobe pairs: `pin_rd`/`pin_wr` active-low strobes, `pin_a0`=0 enables lane `dq_in[7:0]`, `pin_bhe`=0 enables lane `dq_in[15:8]`), a two-lane write stores `dq_in[7:0]` first and `dq_in[15:8]` second.
- R3: With `conv_sel`=1 (`pin_rd` is read/write with 1=read, `pin_wr` is the active-low low-lane strobe, `pin_bhe` is the active-low high-lane strobe), a two-lane write stores `dq_in[15:8]` first and `dq_in[7:0]` second.
- R4: A single-lane write stores only the byte of the enabled lane.
- R5: On a bus read with `xfer_dir`=1, `dq_oe` is 1 while the synchronized read strobe is active and `dack` is high, and 0 otherwise. For a two-lane read, the oldest FIFO byte appears on `dq_out[7:0]` when `conv_sel`=0 and on `dq_out[15:8]` when `conv_sel`=1, with the next byte on the other lane. A single-lane read places the oldest byte on the enabled lane. Each `dpar_out` bit (bit 0 for the low lane) makes its byte's parity odd, and each read pops the bytes it presented.
- R6: Parity is odd: a written byte whose 9 bits hold an even number of ones sets `par_err`. The byte is still stored. `par_err` stays set until `start`.
- R7: Strobes have no effect while `dack` is 0.
- R8: In write direction (`xfer_dir`=0), `dreq` is 0 when the FIFO lacks room for the next transfer. In read direction, `dreq` is 0 when the FIFO does not hold enough bytes for it.
- R9: `start` loads `total_len`. `dreq` is 0 once that many bytes have been transferred.
- R10: The byte count within a block returns to 0 after each `blk_len` bytes. With the count at 0 and `permit` low, `dreq` stays 0 until `permit` returns. A `permit` drop in mid-block does not stop the block.
- R11: With `conv_sel`=1, `pin_a0` has no effect.
- R12: A transfer is committed only when its strobe is released: `fifo_level` does not change while a write strobe is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| conv_sel | input | 1 | Bus convention: 0 strobe pairs, 1 direction line with lane strobes |
| xfer_dir | input | 1 | 0: bus writes fill FIFO; 1: bus reads drain FIFO |
| start | input | 1 | Loads counters, clears parity flag |
| total_len | input | LW | Bytes in the whole transfer |
| blk_len | input | LW | Bytes per block |
| dack | input | 1 | DMA acknowledge, active high |
| permit | input | 1 | Transfer permit, active high |
| pin_rd | input | 1 | Read strobe (active low) or read/write line |
| pin_wr | input | 1 | Write strobe or low-lane strobe, active low |
| pin_bhe | input | 1 | High-byte enable or high-lane strobe, active low |
| pin_a0 | input | 1 | Address bit 0 (strobe-pair convention only) |
| dq_in | input | 16 | Bus data in |
| dpar_in | input | 2 | Lane parity in, bit 0 low lane |
| dq_out | output | 16 | Bus data out |
| dpar_out | output | 2 | Lane parity out, bit 0 low lane |
| dq_oe | output | 1 | Bus output enable |
| dreq | output | 1 | DMA request |
| par_err | output | 1 | Sticky write parity error |
| core_push | input | 1 | Core pushes one byte (read direction) |
| core_push_data | input | 8 | Byte pushed by the core |
| core_pop | input | 1 | Core pops one byte (write direction) |
| core_pop_data | output | 8 | Oldest FIFO byte |
| fifo_level | output | $clog2(DEPTH)+1 | FIFO byte count |

## Verification
A wrong lane order or a wrong lane enable shows up as a byte out of order at `core_pop_data` on the next drain, or as wrong lanes on `dq_out` while a read strobe is held. Block and total counters that drift show within one transfer as `dreq` held high or low in the wrong place, because the request is recomputed every cycle from those counters. A lost parity error stays lost until a later bad byte arrives, so the flag is checked right after each bad write and again after good ones.

// File: rtl/dsp_pkg.sv
package dsp_pkg;

    typedef enum logic {
        CONV_STROBE_PAIR = 1'b0,
        CONV_DIR_LINE    = 1'b1
    } conv_e;

    typedef struct packed {
        logic active;
        logic rd;
        logic lo;
        logic hi;
    } bus_cyc_t;

    function automatic logic odd_par(input logic [7:0] b);
        return ~(^b);
    endfunction

    function automatic logic par_good(input logic [7:0] b, input logic p);
        return ^{b, p};
    endfunction

endpackage

// File: rtl/dsp_sync.sv
module dsp_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] s1;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1 <= '1;
            q  <= '1;
        end else begin
            s1 <= d;
            q  <= s1;
        end
    end
endmodule

// File: rtl/dsp_decode.sv
module dsp_decode
    import dsp_pkg::*;
(
    input  conv_e    conv,
    input  logic     s_rd,
    input  logic     s_wr,
    input  logic     s_bhe,
    input  logic     s_a0,
    input  logic     ack,
    output bus_cyc_t cyc
);
    always_comb begin
        if (conv == CONV_STROBE_PAIR) begin
            cyc.active = ack & (~s_rd | ~s_wr);
            cyc.rd     = ~s_rd;
            cyc.lo     = ~s_a0;
            cyc.hi     = ~s_bhe;
        end else begin
            cyc.active = ack & (~s_wr | ~s_bhe);
            cyc.rd     = s_rd;
            cyc.lo     = ~s_wr;
            cyc.hi     = ~s_bhe;
        end
    end
endmodule

// File: rtl/dsp_fifo.sv
module dsp_fifo #(
    parameter  int DEPTH = 16,
    localparam int AW    = $clog2(DEPTH),
    localparam int CW    = AW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [1:0]    push_n,
    input  logic [7:0]    push_b0,
    input  logic [7:0]    push_b1,
    input  logic [1:0]    pop_n,
    output logic [7:0]    head0,
    output logic [7:0]    head1,
    output logic [AW:0]   level
);
    logic [7:0]    mem [DEPTH];
    logic [AW-1:0] wp, rp, wp1, rp1;
    logic [AW:0]   cnt;

    assign wp1   = wp + AW'(1);
    assign rp1   = rp + AW'(1);
    assign head0 = mem[rp];
    assign head1 = mem[rp1];
    assign level = cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            wp  <= wp + AW'(push_n);
            rp  <= rp + AW'(pop_n);
            cnt <= cnt + CW'(push_n) - CW'(pop_n);
        end
    end

    always_ff @(posedge clk) begin
        if (push_n != 2'd0) mem[wp]  <= push_b0;
        if (push_n == 2'd2) mem[wp1] <= push_b1;
    end

    // R8: the port never pushes past capacity nor pops more than it holds
    a_r8_no_overflow: assert property (@(posedge clk) disable iff (rst)
        (int'(push_n) + int'(cnt) <= DEPTH + int'(pop_n)));
    a_r8_no_underflow: assert property (@(posedge clk) disable iff (rst)
        (int'(pop_n) <= int'(cnt)));
endmodule

// File: rtl/dma_slave_port.sv
module dma_slave_port
    import dsp_pkg::*;
#(
    parameter  int DEPTH = 16,
    parameter  int LW    = 16,
    localparam int AW    = $clog2(DEPTH),
    localparam int SW    = 24
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          conv_sel,
    input  logic          xfer_dir,
    input  logic          start,
    input  logic [LW-1:0] total_len,
    input  logic [LW-1:0] blk_len,
    input  logic          dack,
    input  logic          permit,
    input  logic          pin_rd,
    input  logic          pin_wr,
    input  logic          pin_bhe,
    input  logic          pin_a0,
    input  logic [15:0]   dq_in,
    input  logic [1:0]    dpar_in,
    output logic [15:0]   dq_out,
    output logic [1:0]    dpar_out,
    output logic          dq_oe,
    output logic          dreq,
    output logic          par_err,
    input  logic          core_push,
    input  logic [7:0]    core_push_data,
    input  logic          core_pop,
    output logic [7:0]    core_pop_data,
    output logic [AW:0]   fifo_level
);
    // ---------------- synchronizers ----------------
    logic [SW-1:0] raw, syn;
    logic          s_rd, s_wr, s_bhe, s_a0, dack_s, permit_s;
    logic [15:0]   dq_s;
    logic [1:0]    dp_s;

    assign raw = {pin_rd, pin_wr, pin_bhe, pin_a0, dack, permit, dpar_in, dq_in};
    assign {s_rd, s_wr, s_bhe, s_a0, dack_s, permit_s, dp_s, dq_s} = syn;

    dsp_sync #(.W(SW)) u_sync (.clk(clk), .rst(rst), .d(raw), .q(syn));

    // ---------------- cycle decode ----------------
    bus_cyc_t cyc, cyc_q;
    conv_e    conv;
    logic     moto;

    assign conv = conv_e'(conv_sel);
    assign moto = (conv == CONV_DIR_LINE);

    dsp_decode u_dec (
        .conv(conv), .s_rd(s_rd), .s_wr(s_wr), .s_bhe(s_bhe),
        .s_a0(s_a0), .ack(dack_s), .cyc(cyc)
    );

    logic [15:0] hold_d;
    logic [1:0]  hold_p;

    always_ff @(posedge clk) begin
        if (rst) begin
            cyc_q  <= '0;
            hold_d <= '0;
            hold_p <= '0;
        end else begin
            cyc_q <= cyc;
            if (cyc.active) begin
                hold_d <= dq_s;
                hold_p <= dp_s;
            end
        end
    end

    logic commit, wr_commit, rd_commit;
    assign commit    = cyc_q.active & ~cyc.active;
    assign wr_commit = commit & ~xfer_dir & ~cyc_q.rd;
    assign rd_commit = commit &  xfer_dir &  cyc_q.rd;

    // ---------------- FIFO and lane mapping ----------------
    logic [1:0]  f_push_n, f_pop_n, nbytes, dma_push_n, dma_pop_n;
    logic [7:0]  f_b0, f_b1, f_h0, f_h1, lo_b, hi_b, first_b, second_b;
    logic [AW:0] f_level;
    int          room;

    assign lo_b   = hold_d[7:0];
    assign hi_b   = hold_d[15:8];
    assign nbytes = {1'b0, cyc_q.lo} + {1'b0, cyc_q.hi};
    assign room   = DEPTH - int'(f_level);

    always_comb begin
        if (cyc_q.lo && cyc_q.hi) begin
            first_b  = moto ? hi_b : lo_b;
            second_b = moto ? lo_b : hi_b;
        end else begin
            first_b  = cyc_q.hi ? hi_b : lo_b;
            second_b = 8'h00;
        end
        dma_push_n = (wr_commit && int'(nbytes) <= room) ? nbytes : 2'd0;
        if (!rd_commit)                        dma_pop_n = 2'd0;
        else if (int'(nbytes) > int'(f_level)) dma_pop_n = f_level[1:0];
        else                                   dma_pop_n = nbytes;
    end

    always_comb begin
        if (xfer_dir) begin
            f_push_n = (core_push && room > 0) ? 2'd1 : 2'd0;
            f_b0     = core_push_data;
            f_b1     = 8'h00;
            f_pop_n  = dma_pop_n;
        end else begin
            f_push_n = dma_push_n;
            f_b0     = first_b;
            f_b1     = second_b;
            f_pop_n  = (core_pop && f_level != '0) ? 2'd1 : 2'd0;
        end
    end

    dsp_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst(rst), .push_n(f_push_n), .push_b0(f_b0), .push_b1(f_b1),
        .pop_n(f_pop_n), .head0(f_h0), .head1(f_h1), .level(f_level)
    );

    assign fifo_level    = f_level;
    assign core_pop_data = f_h0;

    // ---------------- read data presentation ----------------
    always_comb begin
        dq_out = 16'h0000;
        if (cyc.active && cyc.rd) begin
            if (cyc.lo && cyc.hi) dq_out = moto ? {f_h0, f_h1} : {f_h1, f_h0};
            else if (cyc.hi)      dq_out = {f_h0, 8'h00};
            else                  dq_out = {8'h00, f_h0};
        end
    end

    assign dpar_out = {odd_par(dq_out[15:8]), odd_par(dq_out[7:0])};
    assign dq_oe    = cyc.active & cyc.rd & xfer_dir;

    // ---------------- counters and parity flag ----------------
    logic [LW-1:0] rem, blk_cnt, blk_nxt, moved;
    logic          bad;

    assign moved   = (dma_push_n != 2'd0) ? LW'(dma_push_n) : LW'(dma_pop_n);
    assign blk_nxt = (blk_cnt + moved >= blk_len) ? '0 : blk_cnt + moved;
    assign bad     = wr_commit &
                     ((cyc_q.lo & ~par_good(lo_b, hold_p[0])) |
                      (cyc_q.hi & ~par_good(hi_b, hold_p[1])));

    always_ff @(posedge clk) begin
        if (rst) begin
            rem     <= '0;
            blk_cnt <= '0;
            par_err <= 1'b0;
        end else if (start) begin
            rem     <= total_len;
            blk_cnt <= '0;
            par_err <= 1'b0;
        end else begin
            if (moved != '0) begin
                rem     <= (rem > moved) ? rem - moved : '0;
                blk_cnt <= blk_nxt;
            end
            if (bad) par_err <= 1'b1;
        end
    end

    // ---------------- request ----------------
    int  need;
    logic fifo_ok;

    assign need    = (rem >= LW'(2)) ? 2 : 1;
    assign fifo_ok = xfer_dir ? (int'(f_level) >= need) : (room >= need);
    assign dreq    = (rem != '0) & ((blk_cnt != '0) | permit_s) & fifo_ok &
                     ~cyc.active & ~cyc_q.active;

    // R9: no request once the total is exhausted
    a_r9_idle_when_done: assert property (@(posedge clk) disable iff (rst)
        (rem == '0) |-> !dreq);
    // R10: at a block boundary without permit the port waits
    a_r10_hold_at_boundary: assert property (@(posedge clk) disable iff (rst)
        (blk_cnt == '0 && !permit_s) |-> !dreq);
    // R6: the parity flag holds until the next start
    a_r6_sticky_flag: assert property (@(posedge clk) disable iff (rst)
        (par_err && !start) |=> par_err);
    // R7: the bus is never driven without acknowledge
    a_r7_no_drive_without_ack: assert property (@(posedge clk) disable iff (rst)
        !dack_s |-> !dq_oe);
endmodule

// File: tb/sim_dma_slave_port.sv
module sim_dma_slave_port;
    localparam int DEPTH = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        conv_sel = 1'b0, xfer_dir = 1'b0, start = 1'b0;
    logic [15:0] total_len = '0, blk_len = '0;
    logic        dack = 1'b1, permit = 1'b1;
    logic        pin_rd = 1'b1, pin_wr = 1'b1, pin_bhe = 1'b1, pin_a0 = 1'b1;
    logic [15:0] dq_in = '0;
    logic [1:0]  dpar_in = '0;
    logic [15:0] dq_out;
    logic [1:0]  dpar_out;
    logic        dq_oe, dreq, par_err;
    logic        core_push = 1'b0, core_pop = 1'b0;
    logic [7:0]  core_push_data = '0, core_pop_data;
    logic [4:0]  fifo_level;

    int checks = 0;
    int errors = 0;
    logic [7:0] exp_q[$];

    always #10 clk = ~clk;

    dma_slave_port #(.DEPTH(DEPTH), .LW(16)) u0 (
        .clk(clk), .rst(rst), .conv_sel(conv_sel), .xfer_dir(xfer_dir), .start(start),
        .total_len(total_len), .blk_len(blk_len), .dack(dack), .permit(permit),
        .pin_rd(pin_rd), .pin_wr(pin_wr), .pin_bhe(pin_bhe), .pin_a0(pin_a0),
        .dq_in(dq_in), .dpar_in(dpar_in), .dq_out(dq_out), .dpar_out(dpar_out),
        .dq_oe(dq_oe), .dreq(dreq), .par_err(par_err), .core_push(core_push),
        .core_push_data(core_push_data), .core_pop(core_pop),
        .core_pop_data(core_pop_data), .fifo_level(fifo_level)
    );

    function automatic logic opar(input logic [7:0] b);
        return ~(^b);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic go(input logic dir, input logic [15:0] tot, input logic [15:0] blk);
        @(negedge clk);
        xfer_dir = dir; total_len = tot; blk_len = blk; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    // driver: one DMA write cycle, expected bytes go to the scoreboard
    task automatic dma_write(input logic lo, input logic hi, input logic [15:0] w,
                             input logic bad_lo, input logic expect_store);
        @(negedge clk);
        dq_in   = w;
        dpar_in = {opar(w[15:8]), opar(w[7:0]) ^ bad_lo};
        @(negedge clk);
        if (!conv_sel) begin
            pin_a0 = ~lo; pin_bhe = ~hi; pin_wr = 1'b0;
        end else begin
            pin_rd = 1'b0; pin_wr = ~lo; pin_bhe = ~hi;
        end
        repeat (5) @(negedge clk);
        pin_wr = 1'b1; pin_bhe = 1'b1; pin_rd = 1'b1;
        if (!conv_sel) pin_a0 = 1'b1;
        repeat (6) @(negedge clk);
        if (expect_store) begin
            if (lo && hi) begin
                if (!conv_sel) begin exp_q.push_back(w[7:0]);  exp_q.push_back(w[15:8]); end
                else           begin exp_q.push_back(w[15:8]); exp_q.push_back(w[7:0]);  end
            end else if (hi) exp_q.push_back(w[15:8]);
            else             exp_q.push_back(w[7:0]);
        end
    endtask

    // monitor: pop every stored byte and compare with the scoreboard
    task automatic drain(input string req);
        while (fifo_level != 0) begin
            if (exp_q.size() == 0) begin
                chk({req, " extra byte"}, 32'(core_pop_data), 32'hxx);
            end else begin
                chk(req, 32'(core_pop_data), 32'(exp_q.pop_front()));
            end
            @(negedge clk); core_pop = 1'b1;
            @(negedge clk); core_pop = 1'b0;
        end
        chk({req, " scoreboard empty"}, 32'(exp_q.size()), 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual running expected finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        // R1
        chk("R1 dreq", 32'(dreq), 0);
        chk("R1 par_err", 32'(par_err), 0);
        chk("R1 dq_oe", 32'(dq_oe), 0);
        chk("R1 level", 32'(fifo_level), 0);

        // strobe-pair convention writes
        conv_sel = 1'b0;
        go(1'b0, 16'd64, 16'd64);
        chk("R8 dreq with room", 32'(dreq), 1);
        dma_write(1, 1, 16'h2211, 0, 1);                        // R2
        dma_write(0, 1, 16'h3399, 0, 1);                        // R4 high only
        dma_write(1, 0, 16'h8844, 0, 1);                        // R4 low only
        chk("R4 level", 32'(fifo_level), 4);
        drain("R2 R4 order");

        // R12: hold a strobe and watch the level
        @(negedge clk); dq_in = 16'h5566; dpar_in = {opar(8'h55), opar(8'h66)};
        @(negedge clk); pin_a0 = 1'b0; pin_bhe = 1'b0; pin_wr = 1'b0;
        repeat (6) @(negedge clk);
        chk("R12 level while held", 32'(fifo_level), 0);
        pin_wr = 1'b1; pin_bhe = 1'b1; pin_a0 = 1'b1;
        repeat (6) @(negedge clk);
        chk("R12 level after release", 32'(fifo_level), 2);
        exp_q.push_back(8'h66); exp_q.push_back(8'h55);
        drain("R12 data");

        // R6 parity
        chk("R6 flag clear", 32'(par_err), 0);
        dma_write(1, 1, 16'h7E81, 1, 1);
        chk("R6 flag set", 32'(par_err), 1);
        dma_write(1, 1, 16'h0102, 0, 1);
        chk("R6 flag sticky", 32'(par_err), 1);
        drain("R6 bad byte still stored");

        // R7 acknowledge low
        dack = 1'b0;
        repeat (3) @(negedge clk);
        dma_write(1, 1, 16'hDEAD, 0, 0);
        chk("R7 level", 32'(fifo_level), 0);
        dack = 1'b1;
        repeat (3) @(negedge clk);

        // direction-line convention
        conv_sel = 1'b1;
        go(1'b0, 16'd64, 16'd64);
        chk("R6 cleared by start", 32'(par_err), 0);
        dma_write(1, 1, 16'hAABB, 0, 1);                        // R3
        dma_write(0, 1, 16'hC3C4, 0, 1);                        // R4
        pin_a0 = 1'b0;                                          // R11
        dma_write(0, 1, 16'hE1E2, 0, 1);
        dma_write(1, 1, 16'hF1F2, 0, 1);
        pin_a0 = 1'b1;
        chk("R11 level", 32'(fifo_level), 6);
        drain("R3 R4 R11 order");

        // R8 fill
        for (int i = 0; i < DEPTH / 2; i++) dma_write(1, 1, 16'(16'h1000 + i), 0, 1);
        chk("R8 level full", 32'(fifo_level), DEPTH);
        chk("R8 dreq when full", 32'(dreq), 0);
        drain("R8 fill data");
        chk("R8 dreq after drain", 32'(dreq), 1);

        // R9 total count
        go(1'b0, 16'd4, 16'd64);
        dma_write(1, 1, 16'h4142, 0, 1);
        chk("R9 dreq mid", 32'(dreq), 1);
        dma_write(1, 1, 16'h4344, 0, 1);
        chk("R9 dreq done", 32'(dreq), 0);
        drain("R9 data");

        // R10 permit and block boundary
        conv_sel = 1'b0;
        go(1'b0, 16'd64, 16'd4);
        dma_write(1, 1, 16'h5152, 0, 1);
        permit = 1'b0;
        repeat (4) @(negedge clk);
        chk("R10 mid-block continues", 32'(dreq), 1);
        dma_write(1, 1, 16'h5354, 0, 1);
        chk("R10 hold at boundary", 32'(dreq), 0);
        repeat (4) @(negedge clk);
        chk("R10 still held", 32'(dreq), 0);
        permit = 1'b1;
        repeat (4) @(negedge clk);
        chk("R10 resumes", 32'(dreq), 1);
        drain("R10 data");

        // R5 reads
        xfer_dir = 1'b1;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk); core_push = 1'b1; core_push_data = 8'(8'hC1 + i);
        end
        @(negedge clk); core_push = 1'b0;
        go(1'b1, 16'd5, 16'd64);
        chk("R8 read dreq", 32'(dreq), 1);
        @(negedge clk); pin_a0 = 1'b0; pin_bhe = 1'b0; pin_rd = 1'b0;
        repeat (4) @(negedge clk);
        chk("R5 oe", 32'(dq_oe), 1);
        chk("R5 word strobe-pair", 32'(dq_out), 32'h C2C1);
        chk("R5 parity", 32'(dpar_out), 32'({opar(8'hC2), opar(8'hC1)}));
        pin_rd = 1'b1; pin_bhe = 1'b1; pin_a0 = 1'b1;
        repeat (6) @(negedge clk);
        chk("R5 oe released", 32'(dq_oe), 0);
        chk("R5 level", 32'(fifo_level), 3);
        conv_sel = 1'b1;
        @(negedge clk); pin_rd = 1'b1; pin_wr = 1'b0; pin_bhe = 1'b0;
        repeat (4) @(negedge clk);
        chk("R5 word direction-line", 32'(dq_out), 32'h C3C4);
        pin_wr = 1'b1; pin_bhe = 1'b1;
        repeat (6) @(negedge clk);
        chk("R8 read dreq one left", 32'(dreq), 1);
        @(negedge clk); pin_wr = 1'b0;
        repeat (4) @(negedge clk);
        chk("R5 single low lane", 32'(dq_out), 32'h 00C5);
        pin_wr = 1'b1;
        repeat (6) @(negedge clk);
        chk("R5 level empty", 32'(fifo_level), 0);
        chk("R9 read done", 32'(dreq), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule